// File: doc/BRIEF.md
# Video Controller Command Port Decoder

This block sits behind the command and data ports of a tile-based video display controller. It decodes each 16-bit word written to the command port. A word is either a one-word register update or one half of a two-word sequence that sets the memory access address and a 6-bit command code. A pending flag records that the first half of such a sequence has arrived. The block also holds the small register file that the rest of the display controller reads.

When the second command word asks for a DMA transfer and DMA is enabled, the block chooses one of three modes from the top bits of the DMA-source-high register:

- A bus-to-video transfer or a video-memory copy starts on the second command word itself.
- A fill is armed instead. It starts when the next data-port word is accepted, and that word supplies the fill value and the destination address.

While a transfer runs, both ports refuse writes by holding their ready signals low. A length-counter-zero indication from the data mover ends the run.

Both write ports are valid/ready. A word transfers on a rising edge where valid and ready are both high. Ready is low for as long as a DMA transfer runs. A producer may hold valid and its word steady until ready returns, and nothing is lost while it waits. The read strobe, the length-zero input, the register select and all outputs are plain signals.

Top module: `vcmd_decoder`

## Requirements
- R1: After reset the following are all zero: the pending flag, the run flag, the start pulse, the access address, the command code and every register. Both ready outputs are high.
- R2: An accepted command word received while not pending, with bits 15:14 = 2'b10, writes bits 7:0 into the register selected by bits 12:8. The new value is readable from the following cycle, and the pending flag stays clear.
- R3: A register write whose index (bits 12:8) is 24 or more changes no register.
- R4: An accepted command word received while not pending, with bits 15:14 other than 2'b10, does three things. It loads access address bits 13:0 from word bits 13:0 and command code bits 1:0 from word bits 15:14. Address bits 15:14 are kept, and the pending flag is set.
- R5: An accepted command word received while pending does three things. It loads address bits 15:14 from word bits 1:0 and command code bits 5:2 from word bits 7:4. The other address and code bits are kept, and the pending flag clears.
- R6: An accepted data-port word, or a pulse on the command-read strobe, clears the pending flag.
- R7: A DMA request is made by the second command word when the new command code has bit 5 set and register 1 bit 4 is set. If register 23 bits 7:6 are not 2'b10, the run flag rises, the start output pulses high for one cycle and the DMA code output takes the new command code. Without register 1 bit 4, no DMA starts.
- R8: The mode of an immediate DMA is taken from register 23. Bit 7 clear gives mode 2'd0 (bus-to-video), and bits 7:6 = 2'b11 give mode 2'd1 (copy).
- R9: With register 23 bits 7:6 = 2'b10, the request only arms a fill, and the run flag stays low. The next accepted data word then does all of the following:
  - it starts the run;
  - it pulses start;
  - it sets mode 2'd2;
  - it latches that word as the fill value;
  - it latches the access address current at that moment as the fill address.
- R10: While the run flag is set, both ready outputs are low, and writes offered on either port change neither the registers, the address, the code nor the pending flag.
- R11: A high length-zero input while running clears the run flag in the next cycle, after which both ports are ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_valid | input | 1 | Command word offered |
| ctl_ready | output | 1 | Command port can accept (low while DMA runs) |
| ctl_data | input | 16 | Command word |
| ctl_rd | input | 1 | Command-port read strobe; clears pending |
| dat_valid | input | 1 | Data word offered |
| dat_ready | output | 1 | Data port can accept (low while DMA runs) |
| dat_data | input | 16 | Data word |
| dma_len_zero | input | 1 | DMA length counter has reached zero |
| reg_sel | input | 5 | Register file read index |
| reg_val | output | 8 | Register selected by reg_sel (0 if out of range) |
| acc_addr | output | 16 | Current access address |
| acc_code | output | 6 | Current command code |
| cmd_pending | output | 1 | First half of a command sequence received |
| dma_run | output | 1 | DMA transfer running |
| dma_start | output | 1 | One-cycle pulse when a transfer begins |
| dma_mode | output | 2 | 0 bus-to-video, 1 copy, 2 fill |
| dma_code | output | 6 | Command code of the running transfer |
| fill_value | output | 16 | Value captured for a fill |
| fill_addr | output | 16 | Destination address captured for a fill |

## Verification
Each state output (address, code, pending, run, mode, captured values) changes on the rising edge that accepts a word, so it is due one edge after the stimulus. The start pulse is due on that same edge and falls one cycle later. The register read port is combinational from reg_sel, so a register value is due in the same cycle as the select. The bench drives on falling edges and queues expected values just after the accepting rising edge. A monitor compares the queued values on the next falling edge, and register reads hold their select across that edge.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;
  typedef enum logic [1:0] {
    DMA_BUS  = 2'd0,
    DMA_COPY = 2'd1,
    DMA_FILL = 2'd2
  } dma_mode_e;
endpackage

// File: rtl/vcmd_regfile.sv
module vcmd_regfile #(
  parameter int NREGS     = 24,
  parameter int IDXW      = 5,
  parameter int MODE2_IDX = 1,
  parameter int SRCHI_IDX = 23,
  parameter int DMAEN_BIT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [7:0]      wr_val,
  input  logic [IDXW-1:0] rd_idx,
  output logic [7:0]      rd_val,
  output logic            dma_en,
  output logic [1:0]      src_top
);
  logic [7:0] regs [NREGS];
  logic       in_range;

  assign in_range = int'(wr_idx) < NREGS;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                       regs[g] <= '0;
      else if (wr_en && in_range && int'(wr_idx) == g)  regs[g] <= wr_val;
    end

    // R3
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && int'(wr_idx) == g) |=> $stable(regs[g]));
  end

  assign rd_val  = (int'(rd_idx) < NREGS) ? regs[rd_idx] : 8'h00;
  assign dma_en  = regs[MODE2_IDX][DMAEN_BIT];
  assign src_top = regs[SRCHI_IDX][7:6];

  // R2
  reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && in_range |=> regs[$past(wr_idx)] == $past(wr_val));
endmodule

// File: rtl/vcmd_cmd_latch.sv
module vcmd_cmd_latch #(
  parameter int AW = 16,
  parameter int CW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_wr,
  input  logic          second_wr,
  input  logic          clr_pend,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] code,
  output logic          pending
);
  localparam int LOW = AW - 2;
  localparam int HCW = CW - 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= '0;
      code    <= '0;
      pending <= 1'b0;
    end else begin
      if (clr_pend) pending <= 1'b0;
      if (first_wr) begin
        addr[LOW-1:0] <= wdata[LOW-1:0];
        code[1:0]     <= wdata[DW-1 -: 2];
        pending       <= 1'b1;
      end else if (second_wr) begin
        addr[AW-1:LOW] <= wdata[1:0];
        code[CW-1:2]   <= wdata[4 +: HCW];
        pending        <= 1'b0;
      end
    end
  end

  // R4
  first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_wr |=> pending && addr[LOW-1:0] == $past(wdata[LOW-1:0]));
  // R5
  second_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    second_wr |=> !pending && addr[LOW-1:0] == $past(addr[LOW-1:0])
                  && code[1:0] == $past(code[1:0]));
  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend && !first_wr |=> !pending);
endmodule

// File: rtl/vcmd_dma_ctl.sv
module vcmd_dma_ctl
  import vcmd_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_done,
  input  logic [CW-1:0] new_code,
  input  logic          dma_en,
  input  logic [1:0]    src_top,
  input  logic          ctl_fire,
  input  logic          dat_fire,
  input  logic [DW-1:0] dat_word,
  input  logic [AW-1:0] cur_addr,
  input  logic          len_zero,
  output logic          dma_run,
  output logic          dma_start,
  output dma_mode_e     dma_mode,
  output logic [CW-1:0] dma_code,
  output logic [DW-1:0] fill_value,
  output logic [AW-1:0] fill_addr
);
  logic          fill_armed;
  logic [CW-1:0] arm_code;
  logic          request;

  assign request = cmd_done && new_code[CW-1] && dma_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_run    <= 1'b0;
      dma_start  <= 1'b0;
      dma_mode   <= DMA_BUS;
      dma_code   <= '0;
      fill_value <= '0;
      fill_addr  <= '0;
      fill_armed <= 1'b0;
      arm_code   <= '0;
    end else begin
      dma_start <= 1'b0;
      if (dma_run && len_zero) dma_run <= 1'b0;
      if (request) begin
        if (src_top != 2'b10) begin
          dma_run    <= 1'b1;
          dma_start  <= 1'b1;
          dma_code   <= new_code;
          dma_mode   <= src_top[1] ? DMA_COPY : DMA_BUS;
          fill_armed <= 1'b0;
        end else begin
          fill_armed <= 1'b1;
          arm_code   <= new_code;
        end
      end else if (ctl_fire) begin
        fill_armed <= 1'b0;
      end
      if (dat_fire && fill_armed) begin
        dma_run    <= 1'b1;
        dma_start  <= 1'b1;
        dma_mode   <= DMA_FILL;
        dma_code   <= arm_code;
        fill_value <= dat_word;
        fill_addr  <= cur_addr;
        fill_armed <= 1'b0;
      end
    end
  end

  // R11
  run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_run && len_zero |=> !dma_run);
  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_run) |-> dma_start);
  // R9
  fill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_armed && dat_fire |=> dma_start && dma_mode == DMA_FILL
                               && fill_value == $past(dat_word));
endmodule

// File: rtl/vcmd_decoder.sv
module vcmd_decoder
  import vcmd_pkg::*;
#(
  parameter int NREGS = 24,
  parameter int IDXW  = 5,
  parameter int AW    = 16,
  parameter int CW    = 6,
  parameter int DW    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_valid,
  output logic            ctl_ready,
  input  logic [DW-1:0]   ctl_data,
  input  logic            ctl_rd,
  input  logic            dat_valid,
  output logic            dat_ready,
  input  logic [DW-1:0]   dat_data,
  input  logic            dma_len_zero,
  input  logic [IDXW-1:0] reg_sel,
  output logic [7:0]      reg_val,
  output logic [AW-1:0]   acc_addr,
  output logic [CW-1:0]   acc_code,
  output logic            cmd_pending,
  output logic            dma_run,
  output logic            dma_start,
  output logic [1:0]      dma_mode,
  output logic [CW-1:0]   dma_code,
  output logic [DW-1:0]   fill_value,
  output logic [AW-1:0]   fill_addr
);
  logic          ctl_fire, dat_fire;
  logic          reg_wr, first_wr, second_wr;
  logic          dma_en;
  logic [1:0]    src_top;
  logic [CW-1:0] new_code;
  dma_mode_e     mode_q;

  assign ctl_ready = !dma_run;
  assign dat_ready = !dma_run;
  assign ctl_fire  = ctl_valid && ctl_ready;
  assign dat_fire  = dat_valid && dat_ready;

  assign reg_wr    = ctl_fire && !cmd_pending && ctl_data[DW-1 -: 2] == 2'b10;
  assign first_wr  = ctl_fire && !cmd_pending && ctl_data[DW-1 -: 2] != 2'b10;
  assign second_wr = ctl_fire && cmd_pending;
  assign new_code  = {ctl_data[4 +: CW-2], acc_code[1:0]};
  assign dma_mode  = mode_q;

  vcmd_regfile #(.NREGS(NREGS), .IDXW(IDXW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_idx  (ctl_data[8 +: IDXW]),
    .wr_val  (ctl_data[7:0]),
    .rd_idx  (reg_sel),
    .rd_val  (reg_val),
    .dma_en  (dma_en),
    .src_top (src_top)
  );

  vcmd_cmd_latch #(.AW(AW), .CW(CW), .DW(DW)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .first_wr  (first_wr),
    .second_wr (second_wr),
    .clr_pend  (dat_fire || ctl_rd),
    .wdata     (ctl_data),
    .addr      (acc_addr),
    .code      (acc_code),
    .pending   (cmd_pending)
  );

  vcmd_dma_ctl #(.AW(AW), .CW(CW), .DW(DW)) u_dma (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_done   (second_wr),
    .new_code   (new_code),
    .dma_en     (dma_en),
    .src_top    (src_top),
    .ctl_fire   (ctl_fire),
    .dat_fire   (dat_fire),
    .dat_word   (dat_data),
    .cur_addr   (acc_addr),
    .len_zero   (dma_len_zero),
    .dma_run    (dma_run),
    .dma_start  (dma_start),
    .dma_mode   (mode_q),
    .dma_code   (dma_code),
    .fill_value (fill_value),
    .fill_addr  (fill_addr)
  );

  // R10
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_run && !dma_len_zero && !ctl_rd |=> $stable(acc_addr) && $stable(acc_code)
                                            && $stable(cmd_pending));
endmodule

// File: tb/vcmd_decoder_tb.sv
module vcmd_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_valid = 1'b0, ctl_rd = 1'b0, dat_valid = 1'b0, dma_len_zero = 1'b0;
  logic [15:0] ctl_data = '0, dat_data = '0;
  logic [4:0]  reg_sel = '0;
  logic        ctl_ready, dat_ready, cmd_pending, dma_run, dma_start;
  logic [7:0]  reg_val;
  logic [15:0] acc_addr, fill_value, fill_addr;
  logic [5:0]  acc_code, dma_code;
  logic [1:0]  dma_mode;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  string       rq[$];
  int          iq[$];
  logic [15:0] vq[$];

  always #4 clk = ~clk;

  vcmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
    .ctl_data(ctl_data), .ctl_rd(ctl_rd), .dat_valid(dat_valid), .dat_ready(dat_ready),
    .dat_data(dat_data), .dma_len_zero(dma_len_zero), .reg_sel(reg_sel), .reg_val(reg_val),
    .acc_addr(acc_addr), .acc_code(acc_code), .cmd_pending(cmd_pending), .dma_run(dma_run),
    .dma_start(dma_start), .dma_mode(dma_mode), .dma_code(dma_code),
    .fill_value(fill_value), .fill_addr(fill_addr)
  );

  localparam int S_PEND = 0, S_RUN = 1, S_START = 2, S_MODE = 3, S_DCODE = 4,
                 S_ADDR = 5, S_CODE = 6, S_FVAL = 7, S_FADDR = 8, S_REG = 9,
                 S_CRDY = 10, S_DRDY = 11;

  function automatic logic [15:0] peek(int id);
    case (id)
      S_PEND:  return {15'd0, cmd_pending};
      S_RUN:   return {15'd0, dma_run};
      S_START: return {15'd0, dma_start};
      S_MODE:  return {14'd0, dma_mode};
      S_DCODE: return {10'd0, dma_code};
      S_ADDR:  return acc_addr;
      S_CODE:  return {10'd0, acc_code};
      S_FVAL:  return fill_value;
      S_FADDR: return fill_addr;
      S_REG:   return {8'd0, reg_val};
      S_CRDY:  return {15'd0, ctl_ready};
      default: return {15'd0, dat_ready};
    endcase
  endfunction

  task automatic expect_val(string req, int id, logic [15:0] v);
    rq.push_back(req); iq.push_back(id); vq.push_back(v);
  endtask

  // Monitor: compares queued expectations on the falling edge
  always @(negedge clk) begin
    while (iq.size() > 0) begin
      string       r;
      int          id;
      logic [15:0] v, act;
      r = rq.pop_front(); id = iq.pop_front(); v = vq.pop_front();
      act = peek(id);
      checks++;
      if (act !== v) begin
        errors++;
        $display("FAIL %s sig=%0d actual=%h expected=%h", r, id, act, v);
      end
    end
  end

  task automatic ctl_wr(logic [15:0] d);
    @(negedge clk); ctl_valid = 1'b1; ctl_data = d;
    @(posedge clk); #1 ctl_valid = 1'b0;
  endtask

  task automatic dat_wr(logic [15:0] d);
    @(negedge clk); dat_valid = 1'b1; dat_data = d;
    @(posedge clk); #1 dat_valid = 1'b0;
  endtask

  task automatic ctl_read();
    @(negedge clk); ctl_rd = 1'b1;
    @(posedge clk); #1 ctl_rd = 1'b0;
  endtask

  task automatic len_zero();
    @(negedge clk); dma_len_zero = 1'b1;
    @(posedge clk); #1 dma_len_zero = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic chk_reg(string req, int idx, logic [7:0] v);
    @(negedge clk); reg_sel = 5'(idx);
    #1 expect_val(req, S_REG, {8'd0, v});
    @(negedge clk); #1;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    expect_val("R1", S_PEND, 0);  expect_val("R1", S_RUN, 0);
    expect_val("R1", S_START, 0); expect_val("R1", S_ADDR, 0);
    expect_val("R1", S_CODE, 0);  expect_val("R1", S_CRDY, 1);
    expect_val("R1", S_DRDY, 1);
    chk_reg("R1", 1, 8'h00);

    // R2: register 1 <= 0x14 (DMA enable), register 23 <= 0x55
    ctl_wr(16'h8114); expect_val("R2", S_PEND, 0);
    ctl_wr(16'h9755);
    chk_reg("R2", 1, 8'h14);
    chk_reg("R2", 23, 8'h55);

    // R3: indices 31 and 24 ignored
    ctl_wr(16'h9F33);
    ctl_wr(16'h98AA);
    chk_reg("R3", 23, 8'h55);
    chk_reg("R3", 0, 8'h00);
    chk_reg("R3", 1, 8'h14);

    // R4: first word
    ctl_wr(16'h4123);
    expect_val("R4", S_PEND, 1); expect_val("R4", S_ADDR, 16'h0123);
    expect_val("R4", S_CODE, 16'h0001);

    // R5: second word, no DMA (code bit5 clear)
    ctl_wr(16'h0012);
    expect_val("R5", S_PEND, 0); expect_val("R5", S_ADDR, 16'h8123);
    expect_val("R5", S_CODE, 16'h0005); expect_val("R7", S_RUN, 0);

    // R6: data write and command read clear pending
    ctl_wr(16'h4000);
    expect_val("R6", S_PEND, 1); expect_val("R4", S_ADDR, 16'h8000);
    dat_wr(16'h1111);
    expect_val("R6", S_PEND, 0);
    ctl_wr(16'h4000);
    ctl_read();
    expect_val("R6", S_PEND, 0);

    // R7/R8: immediate bus-to-video DMA
    ctl_wr(16'h4000);
    ctl_wr(16'h0080);
    expect_val("R7", S_RUN, 1); expect_val("R7", S_START, 1);
    expect_val("R7", S_DCODE, 16'h0021); expect_val("R8", S_MODE, 0);
    idle();
    expect_val("R7", S_START, 0); expect_val("R7", S_RUN, 1);

    // R10: lockout while running
    expect_val("R10", S_CRDY, 0); expect_val("R10", S_DRDY, 0);
    ctl_wr(16'h8100);
    ctl_wr(16'h4FFF);
    dat_wr(16'h2222);
    expect_val("R10", S_PEND, 0); expect_val("R10", S_ADDR, 16'h0000);
    expect_val("R10", S_CODE, 16'h0021);
    chk_reg("R10", 1, 8'h14);

    // R11: end of run
    len_zero();
    expect_val("R11", S_RUN, 0); expect_val("R11", S_CRDY, 1);

    // R8: copy
    ctl_wr(16'h97C0);
    ctl_wr(16'h4000);
    ctl_wr(16'h00C0);
    expect_val("R8", S_RUN, 1); expect_val("R8", S_MODE, 1);
    expect_val("R8", S_DCODE, 16'h0031);
    len_zero();
    expect_val("R11", S_RUN, 0);

    // R7: DMA disabled -> no start
    ctl_wr(16'h8104);
    ctl_wr(16'h4000);
    ctl_wr(16'h0080);
    expect_val("R7", S_RUN, 0); expect_val("R7", S_START, 0);
    ctl_wr(16'h8114);

    // R9: fill deferred to next data word
    ctl_wr(16'h9780);
    ctl_wr(16'h4010);
    ctl_wr(16'h0081);
    expect_val("R9", S_RUN, 0); expect_val("R9", S_START, 0);
    expect_val("R9", S_ADDR, 16'h4010);
    dat_wr(16'hBEEF);
    expect_val("R9", S_RUN, 1); expect_val("R9", S_START, 1);
    expect_val("R9", S_MODE, 2); expect_val("R9", S_FVAL, 16'hBEEF);
    expect_val("R9", S_FADDR, 16'h4010); expect_val("R9", S_DCODE, 16'h0021);
    len_zero();
    expect_val("R11", S_RUN, 0);

    @(negedge clk); #1;
    done = 1'b1;
    summary();
  end
endmodule